// File: doc/BRIEF.md
# Single-to-Double Float Widening Unit

This unit turns a 32-bit IEEE-754 single-precision bit pattern into the 64-bit double-precision pattern that holds exactly the same value. The conversion is exact, so no rounding takes place. It is built from wiring and a few small bit operations rather than from an adder-based rebias. Normal numbers, signed zeros, infinities, quiet and signaling NaNs and subnormal inputs are all covered.

A subnormal single is a normal number once it is widened to double. The unit finds the leading one of such an input with a leading-zero counter. It then shifts the magnitude so that this one lands on the implicit-bit position, drops it, and picks an exponent that matches the shift.

The interface is one valid/data pair in and one registered valid/data pair out, with a fixed latency of one cycle. No flags are raised. The result register loads only on cycles where the input is valid.

Top module: `fp_widen_s2d`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier. An active-low synchronous reset clears `out_valid` and `out_data` to zero.
- R2: For every input class, output bit 63 equals input bit 31 (the sign).
- R3: For an input exponent field (bits 30:23) in 1..254, the output exponent field (bits 62:52) is built as follows: bit 62 equals input bit 30, bits 61:59 are each the inverse of input bit 30, and bits 58:52 equal input bits 29:23. This equals the input exponent plus 896.
- R4: For an input exponent field in 1..255, output bits 51:29 equal input bits 22:0 and output bits 28:0 are zero.
- R5: For an input exponent field of 255, the output exponent field is 0x7FF. An infinity therefore widens to an infinity, and a NaN keeps its 23-bit payload in output bits 51:29.
- R6: A NaN is never quieted. Output bit 51 equals input bit 22, so 0x7F800001 widens to 0x7FF0000020000000.
- R7: An input whose bits 30:0 are zero widens to the input sign in bit 63 with bits 62:0 zero.
- R8: For a subnormal input (exponent field 0, fraction not zero), let k be the number of leading zeros of the 32-bit word `{0, in[30:0]}` and let s = k − 8, which lies in 1..23. The output exponent field is then 897 − s, a value in 874..896.
- R9: For a subnormal input, the fraction is shifted left by s. Its bits below the leading one then fill output bits 51:29, the leading one itself is dropped, and bits 28:0 are zero. For example, 0x00000001 widens to 0x36A0000000000000 and 0x00055555 widens to 0x37C5555400000000.
- R10: On a cycle with `in_valid` low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 32 | Single-precision bit pattern |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 64 | Double-precision bit pattern |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- that the sign is carried through;
- the forced all-ones exponent and the kept quiet bit on infinities and NaNs;
- that zeros collapse to the sign alone;
- that the low 29 result bits are clear on the normal path;
- that a subnormal's exponent stays inside its 874..896 window.

Only the bench's scenarios show that each bit is exactly right against the reference model. This covers the exact renormalized fraction and exponent for each subnormal leading-one position, with sparse and dense patterns, the exponent remapping across the normal range, and back-to-back streams.

// File: rtl/sp2dp_pkg.sv
package sp2dp_pkg;
    localparam int SP_W      = 32;
    localparam int DP_W      = 64;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_BIAS   = 127;
    localparam int DP_BIAS   = 1023;
    // derived
    localparam int MAG_W     = SP_W - 1;
    localparam int FRAC_PAD  = DP_FRAC_W - SP_FRAC_W;
    localparam int EXP_FILL  = DP_EXP_W - SP_EXP_W;
    localparam int SUB_BASE  = DP_BIAS - SP_BIAS + 1;
    localparam int LZC_W     = $clog2(SP_W + 1);

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_SUB  = 2'd1,
        CLS_NORM = 2'd2,
        CLS_TOP  = 2'd3
    } sp_class_e;

    typedef struct packed {
        logic            vld;
        logic [DP_W-1:0] data;
    } widen_reg_t;
endpackage

// File: rtl/sp2dp_lzc.sv
module sp2dp_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    // Scan upward so the highest set bit wins.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/sp2dp_subnorm.sv
module sp2dp_subnorm
    import sp2dp_pkg::*;
(
    input  logic [MAG_W-1:0]     mag,
    output logic [DP_EXP_W-1:0]  exp_o,
    output logic [DP_FRAC_W-1:0] frac_o
);
    logic [LZC_W-1:0]     lz;
    logic [LZC_W-1:0]     shamt;
    logic [SP_FRAC_W-1:0] below_one;

    sp2dp_lzc #(.W(SP_W), .CW(LZC_W)) u_lzc (
        .vec   ({1'b0, mag}),
        .count (lz)
    );

    always_comb begin
        // place leading one on the implicit-bit position (bit SP_FRAC_W)
        shamt     = lz - LZC_W'(SP_EXP_W);
        below_one = SP_FRAC_W'({1'b0, mag} << shamt);
        exp_o     = DP_EXP_W'(SUB_BASE) - DP_EXP_W'(shamt);
        frac_o    = {below_one, {FRAC_PAD{1'b0}}};
    end
endmodule

// File: rtl/sp2dp_fastpath.sv
module sp2dp_fastpath
    import sp2dp_pkg::*;
(
    input  logic [SP_W-1:0] op,
    input  logic            exp_max,
    output logic [DP_W-1:0] res
);
    logic                top_e;
    logic [DP_EXP_W-1:0] e_d;

    always_comb begin
        top_e = op[SP_W-2];
        e_d   = {top_e, {EXP_FILL{~top_e}}, op[SP_W-3:SP_FRAC_W]};
        if (exp_max) e_d = '1;
        res   = {op[SP_W-1], e_d, op[SP_FRAC_W-1:0], {FRAC_PAD{1'b0}}};
    end
endmodule

// File: rtl/fp_widen_s2d.sv
module fp_widen_s2d
    import sp2dp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_data,
    output logic            out_valid,
    output logic [63:0]     out_data
);
    sp_class_e            cls;
    logic [SP_EXP_W-1:0]  e_in;
    logic [DP_W-1:0]      fast_res;
    logic [DP_EXP_W-1:0]  sub_exp;
    logic [DP_FRAC_W-1:0] sub_frac;
    widen_reg_t           st_d, st_q;

    assign e_in = in_data[SP_W-2:SP_FRAC_W];

    always_comb begin
        if (e_in == '1)                          cls = CLS_TOP;
        else if (e_in != '0)                     cls = CLS_NORM;
        else if (in_data[SP_FRAC_W-1:0] != '0)   cls = CLS_SUB;
        else                                     cls = CLS_ZERO;
    end

    sp2dp_fastpath u_fast (
        .op      (in_data),
        .exp_max (cls == CLS_TOP),
        .res     (fast_res)
    );

    sp2dp_subnorm u_sub (
        .mag    (in_data[MAG_W-1:0]),
        .exp_o  (sub_exp),
        .frac_o (sub_frac)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (cls)
                CLS_ZERO: st_d.data = {in_data[SP_W-1], {(DP_W-1){1'b0}}};
                CLS_SUB:  st_d.data = {in_data[SP_W-1], sub_exp, sub_frac};
                default:  st_d.data = fast_res;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
endmodule

// File: rtl/sp2dp_widen_chk.sv
module sp2dp_widen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic [63:0] out_data
);
    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_data[63] == $past(in_data[31]));
    assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[30:23] != 8'h00) |=> out_data[28:0] == 29'd0);
    assert_top_exp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[30:23] == 8'hFF) |=> out_data[62:52] == 11'h7FF);
    assert_quiet_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[30:23] == 8'hFF) |=> out_data[51] == $past(in_data[22]));
    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[30:0] == 31'd0) |=> out_data[62:0] == 63'd0);
    assert_sub_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[30:23] == 8'h00 && in_data[22:0] != 23'd0)
        |=> (out_data[62:52] >= 11'd874 && out_data[62:52] <= 11'd896));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_valid) |=> $stable(out_data));
endmodule

bind fp_widen_s2d sp2dp_widen_chk u_chk (.*);

// File: tb/fp_widen_s2d_tb.sv
module fp_widen_s2d_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    fp_widen_s2d u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    // reference widening, written from the value definition
    function automatic logic [63:0] ref_widen(input logic [31:0] x);
        logic [7:0]  e;
        logic [22:0] f;
        logic [63:0] t;
        int          de;
        int          p;
        e = x[30:23];
        f = x[22:0];
        if (e == 8'h00 && f == 23'd0) return {x[31], 63'd0};
        if (e == 8'hFF) return {x[31], 11'h7FF, f, 29'd0};
        if (e != 8'h00) begin
            de = int'(e) - 127 + 1023;
            return {x[31], de[10:0], f, 29'd0};
        end
        p = 0;
        for (int i = 0; i < 23; i++) if (f[i]) p = i;
        de = p - 149 + 1023;
        t  = 64'(f) << (52 - p);
        return {x[31], de[10:0], t[51:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R1 valid"}, 64'(out_valid), 64'd1);
        chk(tag, out_data, ref_widen(x));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset data", out_data, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_normals();
        apply("R3 R4 one", 32'h3F800000);
        apply("R2 R3 minus two", 32'hC0000000);
        apply("R3 R4 min normal", 32'h00800000);
        apply("R3 R4 max finite", 32'h7F7FFFFF);
        apply("R2 R4 neg pattern", 32'hBEAAAAAB);
        for (int i = 1; i < 255; i += 17)
            apply("R3 exp sweep", {1'b0, 8'(i), 23'h2D5A1F});
    endtask

    task automatic t_specials();
        apply("R5 plus inf", 32'h7F800000);
        apply("R2 R5 minus inf", 32'hFF800000);
        apply("R5 quiet nan", 32'h7FC12345);
        apply("R6 signaling nan", 32'h7F800001);
        chk("R6 exact snan", out_data, 64'h7FF0000020000000);
        apply("R6 neg signaling payload", 32'hFFBFFFFF);
    endtask

    task automatic t_zeros();
        apply("R7 plus zero", 32'h00000000);
        apply("R2 R7 minus zero", 32'h80000000);
        chk("R7 minus zero exact", out_data, 64'h8000000000000000);
    endtask

    task automatic t_subnormals();
        apply("R8 R9 smallest", 32'h00000001);
        chk("R8 R9 smallest exact", out_data, 64'h36A0000000000000);
        apply("R8 R9 dense", 32'h00055555);
        chk("R8 R9 dense exact", out_data, 64'h37C5555400000000);
        apply("R8 R9 largest", 32'h007FFFFF);
        apply("R2 R9 neg sub", 32'h80400001);
        for (int b = 0; b < 23; b++) begin
            apply("R8 single bit", 32'(1) << b);
            apply("R9 all below", (32'(1) << (b + 1)) - 32'd1);
        end
        for (int k = 0; k < 150; k++)
            apply("R8 R9 random sub", {1'b0, 8'h00, 23'($urandom)});
    endtask

    task automatic t_stream();
        logic [31:0] prev;
        prev = 32'h0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k > 0) chk("R1 stream", out_data, ref_widen(prev));
            prev     = $urandom;
            in_valid = 1'b1;
            in_data  = prev;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 stream last", out_data, ref_widen(prev));
    endtask

    task automatic t_hold();
        logic [63:0] held;
        apply("R10 setup", 32'h40490FDB);
        held = out_data;
        in_data = 32'h7F800000;
        repeat (3) @(negedge clk);
        chk("R1 idle valid", 64'(out_valid), 64'd0);
        chk("R10 hold", out_data, held);
    endtask

    initial begin
        t_reset();
        t_normals();
        t_specials();
        t_zeros();
        t_subnormals();
        t_stream();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule